// File: doc/BRIEF.md
# Byte-Pair Camera Pixel Capture

This block sits right after the pins of a parallel CMOS camera and runs on the camera's pixel clock. The camera sends each 16-bit RGB 5:6:5 pixel as two 8-bit bytes while its line-active signal is high. A frame-sync signal separates frames. The block pairs the bytes into one pixel word and tracks column and row positions in the incoming raster. It forwards only the pixels that fall inside a fixed crop window, so that a 640x480 camera frame fits a 480x272 display.

Each forwarded pixel appears as a one-cycle valid strobe. The strobe comes with the joined word, the three colour fields split out, and the pixel's column and row inside the window. Two markers flag the last pixel of every cropped line and the last pixel of the cropped frame. By default the window is centred: columns 80 to 559 and rows 104 to 375. All sizes and offsets are parameters.

Top module: `cam_pixel_capture`

## Requirements
- R1: While `rst_n` is low, `pix_valid`, `line_last` and `frame_last` are low, and `pix_word`, `pix_x` and `pix_y` are zero.
- R2: A pixel is formed only after both of its bytes have been sampled with `cam_href` high. The byte sampled first becomes `pix_word[15:8]` and the byte sampled second becomes `pix_word[7:0]`. `pix_valid` rises in the cycle after the clock edge that samples the second byte.
- R3: `pix_red` equals `pix_word[15:11]`, `pix_green` equals `pix_word[10:5]` and `pix_blue` equals `pix_word[4:0]`.
- R4: Whenever `cam_href` is sampled low, the byte pairing returns to the first-byte state. A line with an odd number of bytes therefore drops its leftover byte, and the next line pairs correctly.
- R5: The source column counts completed pixels within a line, starting at 0. A falling edge of `cam_href` advances the source row by one and clears the column.
- R6: A cycle with `cam_vsync` sampled high clears both the source row and the source column to 0.
- R7: A pixel is forwarded with `pix_valid` high only when its source column lies in [WIN_X0, WIN_X0+WIN_W) and its source row lies in [WIN_Y0, WIN_Y0+WIN_H). When it is forwarded, `pix_x` = column − WIN_X0 and `pix_y` = row − WIN_Y0. All other pixels are dropped.
- R8: `line_last` is high exactly with the forwarded pixel whose `pix_x` equals WIN_W−1, which gives one pulse per cropped line.
- R9: `frame_last` is high exactly with the forwarded pixel at `pix_x` = WIN_W−1 and `pix_y` = WIN_H−1, which gives one pulse per complete cropped frame.
- R10: `pix_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Camera pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_vsync | input | 1 | Frame sync, high between frames |
| cam_href | input | 1 | Line active, high while bytes of a line arrive |
| cam_data | input | 8 | Camera byte bus |
| pix_valid | output | 1 | One-cycle strobe for a forwarded pixel |
| pix_word | output | 16 | Joined RGB 5:6:5 pixel |
| pix_red | output | 5 | Red field |
| pix_green | output | 6 | Green field |
| pix_blue | output | 5 | Blue field |
| pix_x | output | $clog2(WIN_W) | Column inside the crop window |
| pix_y | output | $clog2(WIN_H) | Row inside the crop window |
| line_last | output | 1 | Last forwarded pixel of a cropped line |
| frame_last | output | 1 | Last forwarded pixel of the cropped frame |

## Verification
The assertions assume that `cam_vsync` and `cam_href` are never high together. They also assume the window lies inside the source raster, so that WIN_X0+WIN_W does not exceed SRC_W and WIN_Y0+WIN_H does not exceed SRC_H. The stimulus holds the line-active signal low for the whole of every frame-sync interval. It uses a shrunken raster whose window sits well inside it. Some lines get one extra byte and some lose one byte, which exercises the pairing reset. One frame is cut short by an early frame sync.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

  typedef struct packed {
    logic [4:0] r;
    logic [5:0] g;
    logic [4:0] b;
  } rgb565_t;

  // first byte on the bus is the upper half of the pixel
  function automatic logic [15:0] join_bytes(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic rgb565_t split_rgb(input logic [15:0] w);
    return rgb565_t'(w);
  endfunction

  // true when v lies in the half-open span [lo, lo+len)
  function automatic logic in_span(input int v, input int lo, input int len);
    return (v >= lo) && (v < lo + len);
  endfunction

endpackage

// File: rtl/cam_byte_pair.sv
module cam_byte_pair (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        href,
  input  logic [7:0]  data,
  output logic        pair_valid,
  output logic [15:0] pair_word,
  output logic        phase
);
  import cam_cap_pkg::*;

  logic [7:0] hi_q;
  logic       phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
    end else if (!href) begin
      phase_q <= 1'b0;
    end else begin
      if (!phase_q) hi_q <= data;
      phase_q <= ~phase_q;
    end
  end

  assign pair_valid = href & phase_q;
  assign pair_word  = join_bytes(hi_q, data);
  assign phase      = phase_q;

endmodule

// File: rtl/cam_raster_count.sv
module cam_raster_count #(
  parameter int COL_W = 10,
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             href,
  input  logic             vsync,
  input  logic             pair_valid,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row
);
  localparam logic [COL_W-1:0] COL_MAX = {COL_W{1'b1}};
  localparam logic [ROW_W-1:0] ROW_MAX = {ROW_W{1'b1}};

  logic href_d;
  logic line_fall;

  assign line_fall = href_d & ~href;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      href_d <= 1'b0;
      col    <= '0;
      row    <= '0;
    end else begin
      href_d <= href;
      if (vsync) begin
        col <= '0;
        row <= '0;
      end else if (line_fall) begin
        col <= '0;
        if (row != ROW_MAX) row <= row + 1'b1;
      end else if (pair_valid && col != COL_MAX) begin
        col <= col + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cam_crop_window.sv
module cam_crop_window #(
  parameter int WIN_X0 = 80,
  parameter int WIN_W  = 480,
  parameter int WIN_Y0 = 104,
  parameter int WIN_H  = 272,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 9,
  parameter int OX_W   = 9,
  parameter int OY_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_valid,
  input  logic [15:0]      pair_word,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  output logic             hit,
  output logic             out_valid,
  output logic [15:0]      out_word,
  output logic [OX_W-1:0]  out_x,
  output logic [OY_W-1:0]  out_y,
  output logic             out_eol,
  output logic             out_eof
);
  import cam_cap_pkg::*;

  logic [OX_W-1:0] x_next;
  logic [OY_W-1:0] y_next;
  logic            last_col;
  logic            last_row;
  logic            take;

  assign hit      = in_span(32'(col), WIN_X0, WIN_W) && in_span(32'(row), WIN_Y0, WIN_H);
  assign x_next   = OX_W'(col - COL_W'(WIN_X0));
  assign y_next   = OY_W'(row - ROW_W'(WIN_Y0));
  assign last_col = (x_next == OX_W'(WIN_W - 1));
  assign last_row = (y_next == OY_W'(WIN_H - 1));
  assign take     = pair_valid & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_eol   <= 1'b0;
      out_eof   <= 1'b0;
      out_word  <= '0;
      out_x     <= '0;
      out_y     <= '0;
    end else begin
      out_valid <= take;
      out_eol   <= take & last_col;
      out_eof   <= take & last_col & last_row;
      if (take) begin
        out_word <= pair_word;
        out_x    <= x_next;
        out_y    <= y_next;
      end
    end
  end

endmodule

// File: rtl/cam_pixel_capture.sv
module cam_pixel_capture #(
  parameter int SRC_W  = 640,
  parameter int SRC_H  = 480,
  parameter int WIN_X0 = 80,
  parameter int WIN_W  = 480,
  parameter int WIN_Y0 = 104,
  parameter int WIN_H  = 272,
  localparam int OX_W  = $clog2(WIN_W),
  localparam int OY_W  = $clog2(WIN_H)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cam_vsync,
  input  logic            cam_href,
  input  logic [7:0]      cam_data,
  output logic            pix_valid,
  output logic [15:0]     pix_word,
  output logic [4:0]      pix_red,
  output logic [5:0]      pix_green,
  output logic [4:0]      pix_blue,
  output logic [OX_W-1:0] pix_x,
  output logic [OY_W-1:0] pix_y,
  output logic            line_last,
  output logic            frame_last
);
  import cam_cap_pkg::*;

  localparam int COL_W = $clog2(SRC_W + 1);
  localparam int ROW_W = $clog2(SRC_H + 1);

  // named internal events, observed by the bound checker
  logic             byte_phase;
  logic             pair_fire;
  logic [15:0]      pair_word;
  logic [COL_W-1:0] src_col;
  logic [ROW_W-1:0] src_row;
  logic             win_hit;
  rgb565_t          px;

  cam_byte_pair u_pair (
    .clk        (clk),
    .rst_n      (rst_n),
    .href       (cam_href),
    .data       (cam_data),
    .pair_valid (pair_fire),
    .pair_word  (pair_word),
    .phase      (byte_phase)
  );

  cam_raster_count #(
    .COL_W (COL_W),
    .ROW_W (ROW_W)
  ) u_raster (
    .clk        (clk),
    .rst_n      (rst_n),
    .href       (cam_href),
    .vsync      (cam_vsync),
    .pair_valid (pair_fire),
    .col        (src_col),
    .row        (src_row)
  );

  cam_crop_window #(
    .WIN_X0 (WIN_X0),
    .WIN_W  (WIN_W),
    .WIN_Y0 (WIN_Y0),
    .WIN_H  (WIN_H),
    .COL_W  (COL_W),
    .ROW_W  (ROW_W),
    .OX_W   (OX_W),
    .OY_W   (OY_W)
  ) u_crop (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_valid (pair_fire),
    .pair_word  (pair_word),
    .col        (src_col),
    .row        (src_row),
    .hit        (win_hit),
    .out_valid  (pix_valid),
    .out_word   (pix_word),
    .out_x      (pix_x),
    .out_y      (pix_y),
    .out_eol    (line_last),
    .out_eof    (frame_last)
  );

  assign px        = split_rgb(pix_word);
  assign pix_red   = px.r;
  assign pix_green = px.g;
  assign pix_blue  = px.b;

endmodule

// File: rtl/cam_pixel_capture_chk.sv
module cam_pixel_capture_chk #(
  parameter int WIN_W = 480,
  parameter int WIN_H = 272,
  parameter int OX_W  = 9,
  parameter int OY_W  = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cam_href,
  input logic            pix_valid,
  input logic            line_last,
  input logic            frame_last,
  input logic [OX_W-1:0] pix_x,
  input logic [OY_W-1:0] pix_y,
  input logic            byte_phase,
  input logic            pair_fire
);

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !pix_valid);

  a_r2_valid_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(pair_fire));

  a_r4_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cam_href |=> !byte_phase);

  a_r7_coord_range: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (32'(pix_x) < WIN_W) && (32'(pix_y) < WIN_H));

  a_r8_eol_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    line_last |-> pix_valid && (32'(pix_x) == WIN_W - 1));

  a_r9_eof_at_corner: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |-> line_last && (32'(pix_y) == WIN_H - 1));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

endmodule

bind cam_pixel_capture cam_pixel_capture_chk #(
  .WIN_W (WIN_W),
  .WIN_H (WIN_H),
  .OX_W  (OX_W),
  .OY_W  (OY_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cam_href   (cam_href),
  .pix_valid  (pix_valid),
  .line_last  (line_last),
  .frame_last (frame_last),
  .pix_x      (pix_x),
  .pix_y      (pix_y),
  .byte_phase (byte_phase),
  .pair_fire  (pair_fire)
);

// File: tb/tb_cam_pixel_capture.sv
module tb_cam_pixel_capture;
  localparam int TCLK  = 10;
  localparam int SW    = 16;
  localparam int SH    = 12;
  localparam int X0    = 4;
  localparam int W     = 8;
  localparam int Y0    = 3;
  localparam int H     = 6;
  localparam int OXW   = $clog2(W);
  localparam int OYW   = $clog2(H);

  logic clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  logic           rst_n;
  logic           cam_vsync, cam_href;
  logic [7:0]     cam_data;
  logic           pix_valid, line_last, frame_last;
  logic [15:0]    pix_word;
  logic [4:0]     pix_red, pix_blue;
  logic [5:0]     pix_green;
  logic [OXW-1:0] pix_x;
  logic [OYW-1:0] pix_y;

  cam_pixel_capture #(
    .SRC_W (SW), .SRC_H (SH), .WIN_X0 (X0), .WIN_W (W), .WIN_Y0 (Y0), .WIN_H (H)
  ) dut (
    .clk (clk), .rst_n (rst_n), .cam_vsync (cam_vsync), .cam_href (cam_href),
    .cam_data (cam_data), .pix_valid (pix_valid), .pix_word (pix_word),
    .pix_red (pix_red), .pix_green (pix_green), .pix_blue (pix_blue),
    .pix_x (pix_x), .pix_y (pix_y), .line_last (line_last), .frame_last (frame_last)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // bench model of the capture, built from the requirements
  int          m_phase, m_col, m_row;
  logic [7:0]  m_hi;
  bit          m_prev;
  bit          e_valid, e_eol, e_eof, prev_valid;
  logic [15:0] e_word;
  int          e_x, e_y;
  int          n_eol, n_eof;

  function automatic bit inside_win(int c, int r);
    return (c >= X0) && (c < X0 + W) && (r >= Y0) && (r < Y0 + H);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic tick(bit vs, bit hr, logic [7:0] d);
    @(negedge clk);
    check(pix_valid == e_valid, "R7", "valid", int'(pix_valid), int'(e_valid));
    check(!(pix_valid && prev_valid), "R10", "back-to-back valid", 1, 0);
    if (e_valid) begin
      check(pix_word == e_word, "R2", "word", int'(pix_word), int'(e_word));
      check(pix_red == e_word[15:11] && pix_green == e_word[10:5] && pix_blue == e_word[4:0],
            "R3", "rgb fields", int'({pix_red, pix_green, pix_blue}), int'(e_word));
      check(int'(pix_x) == e_x, "R7", "x", int'(pix_x), e_x);
      check(int'(pix_y) == e_y, "R7", "y", int'(pix_y), e_y);
      check(line_last == e_eol, "R8", "line_last", int'(line_last), int'(e_eol));
      check(frame_last == e_eof, "R9", "frame_last", int'(frame_last), int'(e_eof));
    end else begin
      check(!line_last && !frame_last, "R8", "marker without pixel",
            int'({line_last, frame_last}), 0);
    end
    if (pix_valid && line_last)  n_eol++;
    if (pix_valid && frame_last) n_eof++;
    prev_valid = pix_valid;

    cam_vsync = vs;
    cam_href  = hr;
    cam_data  = d;

    e_valid = 0; e_eol = 0; e_eof = 0;
    if (vs) begin
      m_row = 0; m_col = 0;                       // R6
    end else if (!hr) begin
      if (m_prev) begin m_row++; m_col = 0; end   // R5
    end else if (m_phase == 1) begin
      if (inside_win(m_col, m_row)) begin
        e_valid = 1;
        e_word  = {m_hi, d};                      // R2 first byte on top
        e_x     = m_col - X0;
        e_y     = m_row - Y0;
        e_eol   = (e_x == W - 1);
        e_eof   = e_eol && (e_y == H - 1);
      end
      m_col++;
    end
    if (!hr) m_phase = 0;                         // R4
    else if (m_phase == 0) begin m_hi = d; m_phase = 1; end
    else m_phase = 0;
    m_prev = hr;
  endtask

  // odd_row gets one extra byte, the row after it loses one byte
  task automatic frame(bit rnd, int odd_row, int rows);
    repeat (3) tick(1'b1, 1'b0, 8'h00);
    repeat (2) tick(1'b0, 1'b0, 8'h00);
    for (int r = 0; r < rows; r++) begin
      int nb = 2 * SW;
      if (r == odd_row)     nb = nb + 1;
      if (r == odd_row + 1) nb = nb - 1;
      for (int b = 0; b < nb; b++)
        tick(1'b0, 1'b1, rnd ? 8'($urandom) : 8'(b * 13 + r * 5 + 1));
      repeat (2 + $urandom_range(0, 3)) tick(1'b0, 1'b0, 8'h00);
    end
  endtask

  initial begin
    #(TCLK * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; cam_vsync = 0; cam_href = 0; cam_data = 8'h00;
    m_phase = 0; m_col = 0; m_row = 0; m_hi = 0; m_prev = 0;
    e_valid = 0; e_eol = 0; e_eof = 0; e_word = 0; e_x = 0; e_y = 0; prev_valid = 0;
    repeat (3) @(negedge clk);
    check(!pix_valid && !line_last && !frame_last, "R1", "flags in reset",
          int'({pix_valid, line_last, frame_last}), 0);
    check(pix_word == 16'h0 && pix_x == '0 && pix_y == '0, "R1", "data in reset",
          int'(pix_word), 0);
    rst_n = 1;

    // directed frame; odd-length rows inside the window (R4)
    n_eol = 0; n_eof = 0;
    frame(1'b0, 5, SH);
    check(n_eol == H, "R8", "line_last count", n_eol, H);
    check(n_eof == 1, "R9", "frame_last count", n_eof, 1);

    // frame cut short, then restarted by frame sync (R6)
    frame(1'b1, 20, 6);
    n_eol = 0; n_eof = 0;
    frame(1'b1, 20, SH);
    check(n_eol == H, "R8", "line_last count after restart", n_eol, H);
    check(n_eof == 1, "R9", "frame_last count after restart", n_eof, 1);

    // random frames with random odd rows (R4, R5)
    for (int f = 0; f < 3; f++) begin
      n_eol = 0; n_eof = 0;
      frame(1'b1, $urandom_range(0, SH - 2), SH);
      check(n_eof == 1, "R9", "frame_last count random", n_eof, 1);
    end
    repeat (4) tick(1'b0, 1'b0, 8'h00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule